// File: doc/BRIEF.md
# Slot Power Fault Policy Controller

This block is the digital decision logic that sits next to one drive bay's power switch. It watches three fault flags (over-current, under-voltage, over-temperature) and a power-good input. From them it drives the switch enable and a soft-start ramp select. When a drive is plugged in or asked to power up, the switch turns on and the slot gets a bounded startup window to report power-good. A fault is then handled in one of three ways, chosen separately for each fault class: the slot is shut off and latched, the fault is only recorded while power stays on, or the slot is power-cycled.

Power cycles are rationed. Each retry waits longer than the one before: the wait doubles from a base value and stops growing at a cap. Once the retry budget is spent, the slot stays latched off until a service clear arrives. The retry budget is restored only after the slot has held power-good for a qualification time. This keeps one bad drive from repeatedly pulling the shared supply rail down. Every fault, retry and clear is reported as a one-cycle event that carries the slot number and the slot's running fault count.

Top module: `slot_power_policy`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `state_o` is 0 (off), `sw_en` and `ramp_slow` are 0, `ev_valid` is 0 and `retry_cnt_o` is 0. The fault count is also 0. The state encodings are 0 off, 1 ramp, 2 on, 3 backoff wait and 4 latched off.
- R2: In the off state, a high `pwr_req` moves the slot to ramp on the next edge, with `sw_en` high. A low `pwr_req` in ramp, on or backoff wait returns the slot to off on the next edge.
- R3: In ramp, power-good moves the slot to on. If power-good is absent, `sw_en` stays high for exactly `cfg_win` cycles (`cfg_win` ≥ 1). On expiry the block emits event code 4 (startup timeout), increments the fault count and takes the retry path of R7/R8.
- R4: The fault flags have no effect while the slot is in ramp. Only power-good and window expiry are evaluated there.
- R5: In the on state, each class has a 2-bit response: 00 latches the slot off, 01 records the fault and keeps power on (limit and continue), and 1x takes the retry path. Fault event codes are 1 (over-current), 2 (under-voltage) and 3 (over-temperature). Among non-limit faults that are active together, the lowest code wins, and any non-limit fault takes precedence over limit-only faults.
- R6: A limit-only fault produces one event, code 8 plus the class code (9, 10 or 11), per assertion of its flag. Among several new limit faults, the lowest class is reported first.
- R7: On a retry the switch turns off for min(`cfg_bo_base` << n, `cfg_bo_max`) cycles, with a minimum of 1, where n is the retry count before this retry. The retry count then increases by one. The block then re-enters ramp with event code 5, and `ramp_slow` is high in ramp whenever the retry count is non-zero.
- R8: A retryable fault or timeout that arrives when the retry count already equals `cfg_retry_lim` latches the slot off instead of scheduling a retry.
- R9: The latched-off state keeps `sw_en` low and ignores `pwr_req` and the fault flags until `svc_clr` is seen.
- R10: `svc_clr` acts only in the latched-off state. There it moves the slot to off, clears the retry count and the fault count, and emits event code 6 with count 0. In any other state it has no effect and emits no event.
- R11: After power-good has held for `cfg_qual` consecutive cycles in the on state, the retry count returns to 0.
- R12: Every event reports `ev_slot` equal to the SLOT_ID parameter. Its `ev_count` is the slot's fault count after the event. The count increases by one on each fault or timeout event and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Request to power the slot |
| oc_flt | input | 1 | Over-current flag |
| uv_flt | input | 1 | Under-voltage flag |
| ot_flt | input | 1 | Over-temperature flag |
| pgood | input | 1 | Slot power-good |
| svc_clr | input | 1 | Service clear of a latched slot |
| cfg_rsp_oc | input | 2 | Response for over-current |
| cfg_rsp_uv | input | 2 | Response for under-voltage |
| cfg_rsp_ot | input | 2 | Response for over-temperature |
| cfg_win | input | TW | Startup window in cycles |
| cfg_bo_base | input | TW | First backoff wait in cycles |
| cfg_bo_max | input | TW | Backoff wait cap in cycles |
| cfg_retry_lim | input | RCW | Retries allowed before latch-off |
| cfg_qual | input | TW | Power-good cycles that restore the retry budget |
| sw_en | output | 1 | Power switch enable |
| ramp_slow | output | 1 | Slow soft-start select |
| state_o | output | 3 | Policy state |
| retry_cnt_o | output | RCW | Retries used |
| ev_valid | output | 1 | Event strobe |
| ev_code | output | 4 | Event code |
| ev_slot | output | SIDW | Slot number of the event |
| ev_count | output | CW | Fault count carried by the event |

## Verification
The bench goes after the retry schedule. It checks that the waits follow 2, 4 and then the cap of 6. A design without the cap, or with a doubling that is one retry off, would leave the switch off for the wrong number of cycles. It also checks that the exact retry on which the budget runs out latches the slot. An off-by-one budget would give one extra power cycle or one too few. Fault flags are held high through a startup window whose responses would latch the slot; a design that samples faults in ramp would latch early instead of timing out. The bench also checks that a clear outside the latched state, or a limit fault held for several cycles, produces no extra event, that priority between simultaneous classes follows the codes, and that the retry count clears only after the full qualification time.

// File: rtl/slotpf_pkg.sv
package slotpf_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RAMP  = 3'd1,
        ST_ON    = 3'd2,
        ST_WAIT  = 3'd3,
        ST_LATCH = 3'd4
    } slot_st_e;

    typedef enum logic [3:0] {
        EV_NONE   = 4'd0,
        EV_OC     = 4'd1,
        EV_UV     = 4'd2,
        EV_OT     = 4'd3,
        EV_TMO    = 4'd4,
        EV_RETRY  = 4'd5,
        EV_CLEAR  = 4'd6,
        EV_OC_LIM = 4'd9,
        EV_UV_LIM = 4'd10,
        EV_OT_LIM = 4'd11
    } ev_code_e;

    // response field values
    localparam logic [1:0] RSP_OFF   = 2'b00;
    localparam logic [1:0] RSP_LIMIT = 2'b01;

    localparam int NCLS = 3;

    typedef struct packed {
        logic       hard;     // a latch or retry class fault is active
        logic       retry;    // that fault takes the retry path
        logic [1:0] cls;      // its class index
        logic       lim;      // a fresh limit-only fault is active
        logic [1:0] lim_cls;  // its class index
    } fault_pick_t;

    function automatic ev_code_e fault_code(input logic [1:0] cls, input logic limited);
        return ev_code_e'({limited, 1'b0, cls} + 4'd1);
    endfunction

endpackage

// File: rtl/slotpf_arbiter.sv
module slotpf_arbiter
    import slotpf_pkg::*;
#(
    parameter int NC = NCLS
) (
    input  logic [NC-1:0]   flags,
    input  logic [2*NC-1:0] rsp,
    input  logic [NC-1:0]   seen,
    output fault_pick_t     pick
);

    always_comb begin
        pick = '0;
        // walk from the highest index down so the lowest index wins
        for (int i = NC - 1; i >= 0; i--) begin
            if (flags[i] && (rsp[2*i +: 2] != RSP_LIMIT)) begin
                pick.hard  = 1'b1;
                pick.retry = rsp[2*i+1];
                pick.cls   = 2'(i);
            end
        end
        for (int i = NC - 1; i >= 0; i--) begin
            if (flags[i] && (rsp[2*i +: 2] == RSP_LIMIT) && !seen[i]) begin
                pick.lim     = 1'b1;
                pick.lim_cls = 2'(i);
            end
        end
    end

endmodule

// File: rtl/slotpf_backoff.sv
module slotpf_backoff #(
    parameter int TW  = 16,
    parameter int RCW = 4
) (
    input  logic [TW-1:0]  base,
    input  logic [TW-1:0]  cap,
    input  logic [RCW-1:0] nret,
    output logic [TW-1:0]  wait_o
);

    localparam int WW = 2 * TW;

    logic [WW-1:0] wide;
    logic [WW-1:0] cap_w;

    always_comb begin
        cap_w = WW'(cap);
        if (int'(nret) >= TW) begin
            wide = (base != '0) ? cap_w : '0;
        end else begin
            wide = WW'(base) << nret;
        end
        if (wide > cap_w) begin
            wide = cap_w;
        end
        wait_o = wide[TW-1:0];
        if (wait_o == '0) begin
            wait_o = TW'(1);
        end
    end

endmodule

// File: rtl/slotpf_evlog.sv
module slotpf_evlog
    import slotpf_pkg::*;
#(
    parameter int SLOT_ID = 0,
    parameter int SIDW    = 4,
    parameter int CW      = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [3:0]      code,
    input  logic            is_fault,
    input  logic            clr,
    output logic            ev_valid,
    output logic [3:0]      ev_code,
    output logic [SIDW-1:0] ev_slot,
    output logic [CW-1:0]   ev_count
);

    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;

    always_comb begin
        cnt_n = cnt;
        if (clr) begin
            cnt_n = '0;
        end else if (is_fault && (cnt != '1)) begin
            cnt_n = cnt + ONE_C;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ev_valid <= 1'b0;
            ev_code  <= EV_NONE;
            ev_count <= '0;
        end else begin
            cnt      <= cnt_n;
            ev_valid <= req;
            ev_code  <= req ? code : EV_NONE;
            if (req) begin
                ev_count <= cnt_n;
            end
        end
    end

    assign ev_slot = SIDW'(SLOT_ID);

    // R10: a clear event always reports an empty count
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_code == EV_CLEAR) |-> (ev_count == '0));

    // R12: a saturated count never wraps to a small non-zero value
    p_no_wrap_r12: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> ((cnt == '1) || (cnt == '0)));

endmodule

// File: rtl/slot_power_policy.sv
module slot_power_policy
    import slotpf_pkg::*;
#(
    parameter int SLOT_ID = 0,
    parameter int SIDW    = 4,
    parameter int TW      = 16,
    parameter int RCW     = 4,
    parameter int CW      = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_req,
    input  logic            oc_flt,
    input  logic            uv_flt,
    input  logic            ot_flt,
    input  logic            pgood,
    input  logic            svc_clr,
    input  logic [1:0]      cfg_rsp_oc,
    input  logic [1:0]      cfg_rsp_uv,
    input  logic [1:0]      cfg_rsp_ot,
    input  logic [TW-1:0]   cfg_win,
    input  logic [TW-1:0]   cfg_bo_base,
    input  logic [TW-1:0]   cfg_bo_max,
    input  logic [RCW-1:0]  cfg_retry_lim,
    input  logic [TW-1:0]   cfg_qual,
    output logic            sw_en,
    output logic            ramp_slow,
    output logic [2:0]      state_o,
    output logic [RCW-1:0]  retry_cnt_o,
    output logic            ev_valid,
    output logic [3:0]      ev_code,
    output logic [SIDW-1:0] ev_slot,
    output logic [CW-1:0]   ev_count
);

    localparam logic [TW-1:0]  ONE_T = TW'(1);
    localparam logic [RCW-1:0] ONE_R = RCW'(1);

    slot_st_e          st, st_n;
    logic [TW-1:0]     tmr, tmr_n;
    logic [TW-1:0]     qtmr, qtmr_n;
    logic [TW-1:0]     wait_r, wait_n;
    logic [TW-1:0]     bo_wait;
    logic [RCW-1:0]    rcnt, rcnt_n;
    logic [NCLS-1:0]   flags;
    logic [NCLS-1:0]   lim_seen, lim_n;
    logic [2*NCLS-1:0] rsp_vec;
    fault_pick_t       pick;
    logic              go_retry;
    logic              ev_req;
    logic              ev_fault;
    logic              cnt_clr;
    ev_code_e          ev_code_n;

    assign flags   = {ot_flt, uv_flt, oc_flt};
    assign rsp_vec = {cfg_rsp_ot, cfg_rsp_uv, cfg_rsp_oc};

    slotpf_arbiter #(.NC(NCLS)) u_arb (
        .flags (flags),
        .rsp   (rsp_vec),
        .seen  (lim_seen),
        .pick  (pick)
    );

    slotpf_backoff #(.TW(TW), .RCW(RCW)) u_bo (
        .base   (cfg_bo_base),
        .cap    (cfg_bo_max),
        .nret   (rcnt),
        .wait_o (bo_wait)
    );

    slotpf_evlog #(.SLOT_ID(SLOT_ID), .SIDW(SIDW), .CW(CW)) u_ev (
        .clk      (clk),
        .rst      (rst),
        .req      (ev_req),
        .code     (ev_code_n),
        .is_fault (ev_fault),
        .clr      (cnt_clr),
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .ev_slot  (ev_slot),
        .ev_count (ev_count)
    );

    always_comb begin
        st_n      = st;
        tmr_n     = tmr;
        qtmr_n    = qtmr;
        rcnt_n    = rcnt;
        wait_n    = wait_r;
        lim_n     = (st == ST_ON) ? (lim_seen & flags) : '0;
        go_retry  = 1'b0;
        ev_req    = 1'b0;
        ev_fault  = 1'b0;
        cnt_clr   = 1'b0;
        ev_code_n = EV_NONE;

        unique case (st)
            ST_OFF: begin
                if (pwr_req) begin
                    st_n  = ST_RAMP;
                    tmr_n = '0;
                end
            end
            ST_RAMP: begin
                if (!pwr_req) begin
                    st_n = ST_OFF;
                end else if (pgood) begin
                    st_n   = ST_ON;
                    qtmr_n = '0;
                end else if (tmr == cfg_win - ONE_T) begin
                    ev_req    = 1'b1;
                    ev_fault  = 1'b1;
                    ev_code_n = EV_TMO;
                    go_retry  = 1'b1;
                end else begin
                    tmr_n = tmr + ONE_T;
                end
            end
            ST_ON: begin
                if (!pwr_req) begin
                    st_n = ST_OFF;
                end else if (pick.hard) begin
                    ev_req    = 1'b1;
                    ev_fault  = 1'b1;
                    ev_code_n = fault_code(pick.cls, 1'b0);
                    if (pick.retry) begin
                        go_retry = 1'b1;
                    end else begin
                        st_n = ST_LATCH;
                    end
                end else begin
                    if (pick.lim) begin
                        ev_req    = 1'b1;
                        ev_fault  = 1'b1;
                        ev_code_n = fault_code(pick.lim_cls, 1'b1);
                        lim_n[pick.lim_cls] = 1'b1;
                    end
                    if (pgood) begin
                        if (qtmr == cfg_qual - ONE_T) begin
                            rcnt_n = '0;
                        end
                        if (qtmr != cfg_qual) begin
                            qtmr_n = qtmr + ONE_T;
                        end
                    end else begin
                        qtmr_n = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (!pwr_req) begin
                    st_n = ST_OFF;
                end else if (tmr == wait_r - ONE_T) begin
                    st_n      = ST_RAMP;
                    tmr_n     = '0;
                    ev_req    = 1'b1;
                    ev_code_n = EV_RETRY;
                end else begin
                    tmr_n = tmr + ONE_T;
                end
            end
            ST_LATCH: begin
                if (svc_clr) begin
                    st_n      = ST_OFF;
                    rcnt_n    = '0;
                    cnt_clr   = 1'b1;
                    ev_req    = 1'b1;
                    ev_code_n = EV_CLEAR;
                end
            end
            default: st_n = ST_OFF;
        endcase

        if (go_retry) begin
            if (rcnt >= cfg_retry_lim) begin
                st_n = ST_LATCH;
            end else begin
                st_n   = ST_WAIT;
                rcnt_n = rcnt + ONE_R;
                wait_n = bo_wait;
                tmr_n  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_OFF;
            tmr      <= '0;
            qtmr     <= '0;
            wait_r   <= '0;
            rcnt     <= '0;
            lim_seen <= '0;
        end else begin
            st       <= st_n;
            tmr      <= tmr_n;
            qtmr     <= qtmr_n;
            wait_r   <= wait_n;
            rcnt     <= rcnt_n;
            lim_seen <= lim_n;
        end
    end

    assign sw_en       = (st == ST_RAMP) || (st == ST_ON);
    assign ramp_slow   = (st == ST_RAMP) && (rcnt != '0);
    assign state_o     = st;
    assign retry_cnt_o = rcnt;

    // R4: fault flags cannot move the slot out of ramp before the window ends
    p_ramp_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RAMP && pwr_req && !pgood && tmr != cfg_win - ONE_T) |=> (st == ST_RAMP));

    // R7: the backoff timer never runs past the scheduled wait
    p_wait_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (tmr < wait_r));

    // R7: a retry event is only issued on leaving the backoff wait
    p_retry_src_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_code == EV_RETRY) |-> ($past(st) == ST_WAIT && st == ST_RAMP));

    // R9: a latched slot stays latched without a service clear
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LATCH && !svc_clr) |=> (st == ST_LATCH && !sw_en));

    // R10: a clear event can only follow the latched state
    p_clear_src_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_code == EV_CLEAR) |-> ($past(st) == ST_LATCH));

endmodule

// File: tb/sim_slot_power_policy.sv
module sim_slot_power_policy;

    localparam int CLK_PERIOD = 10;
    localparam int TW  = 16;
    localparam int RCW = 4;
    localparam int CW  = 8;
    localparam int SIDW = 4;
    localparam int SLOT = 3;
    localparam int WIN  = 4;
    localparam int BASE = 2;
    localparam int BMAX = 6;
    localparam int RLIM = 3;
    localparam int QUAL = 6;

    // {flags ot,uv,oc; rsp_ot; rsp_uv; rsp_oc; expected code; expected state}
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {3'b001, 2'b10, 2'b10, 2'b10, 4'd1,  3'd3},
        {3'b010, 2'b10, 2'b00, 2'b10, 4'd2,  3'd4},
        {3'b100, 2'b01, 2'b10, 2'b10, 4'd11, 3'd2},
        {3'b111, 2'b10, 2'b10, 2'b10, 4'd1,  3'd3},
        {3'b110, 2'b00, 2'b01, 2'b10, 4'd3,  3'd4},
        {3'b011, 2'b10, 2'b10, 2'b01, 4'd2,  3'd3},
        {3'b101, 2'b01, 2'b10, 2'b01, 4'd9,  3'd2},
        {3'b010, 2'b10, 2'b11, 2'b10, 4'd2,  3'd3}
    };

    logic clk = 1'b0;
    logic rst, pwr_req, oc_flt, uv_flt, ot_flt, pgood, svc_clr;
    logic [1:0] cfg_rsp_oc, cfg_rsp_uv, cfg_rsp_ot;
    logic [TW-1:0] cfg_win, cfg_bo_base, cfg_bo_max, cfg_qual;
    logic [RCW-1:0] cfg_retry_lim;
    logic sw_en, ramp_slow, ev_valid;
    logic [2:0] state_o;
    logic [RCW-1:0] retry_cnt_o;
    logic [3:0] ev_code;
    logic [SIDW-1:0] ev_slot;
    logic [CW-1:0] ev_count;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slot_power_policy #(.SLOT_ID(SLOT), .SIDW(SIDW), .TW(TW), .RCW(RCW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .oc_flt(oc_flt), .uv_flt(uv_flt),
        .ot_flt(ot_flt), .pgood(pgood), .svc_clr(svc_clr),
        .cfg_rsp_oc(cfg_rsp_oc), .cfg_rsp_uv(cfg_rsp_uv), .cfg_rsp_ot(cfg_rsp_ot),
        .cfg_win(cfg_win), .cfg_bo_base(cfg_bo_base), .cfg_bo_max(cfg_bo_max),
        .cfg_retry_lim(cfg_retry_lim), .cfg_qual(cfg_qual),
        .sw_en(sw_en), .ramp_slow(ramp_slow), .state_o(state_o), .retry_cnt_o(retry_cnt_o),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_slot(ev_slot), .ev_count(ev_count)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pwr_req = 1'b0; oc_flt = 1'b0; uv_flt = 1'b0; ot_flt = 1'b0;
        pgood = 1'b0; svc_clr = 1'b0;
        cfg_rsp_oc = 2'b10; cfg_rsp_uv = 2'b10; cfg_rsp_ot = 2'b10;
        cfg_win = TW'(WIN); cfg_bo_base = TW'(BASE); cfg_bo_max = TW'(BMAX);
        cfg_retry_lim = RCW'(RLIM); cfg_qual = TW'(QUAL);
        step(3);
        rst = 1'b0;
    endtask

    task automatic bring_up();
        pwr_req = 1'b1;
        pgood = 1'b1;
        step(1);
        chk("R2 ramp entry", int'(state_o), 1);
        step(1);
        chk("R3 pgood to on", int'(state_o), 2);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        rst = 1'b1;
        step(1);
        chk("R1 state", int'(state_o), 0);
        chk("R1 sw_en", int'(sw_en), 0);
        chk("R1 ev_valid", int'(ev_valid), 0);
        chk("R1 retry", int'(retry_cnt_o), 0);
        rst = 1'b0;

        // R5 R6 R12: response table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            cfg_rsp_ot = VEC[v][12:11];
            cfg_rsp_uv = VEC[v][10:9];
            cfg_rsp_oc = VEC[v][8:7];
            bring_up();
            {ot_flt, uv_flt, oc_flt} = VEC[v][15:13];
            step(1);
            chk("R5 event valid", int'(ev_valid), 1);
            chk("R5 event code", int'(ev_code), int'(VEC[v][6:3]));
            chk("R5 next state", int'(state_o), int'(VEC[v][2:0]));
            chk("R12 slot id", int'(ev_slot), SLOT);
            chk("R12 count", int'(ev_count), 1);
            {ot_flt, uv_flt, oc_flt} = 3'b000;
        end

        // R3 R4 R7 R8: timeout, backoff schedule and latch-off
        do_reset();
        cfg_rsp_oc = 2'b00; cfg_rsp_uv = 2'b00; cfg_rsp_ot = 2'b00;
        {ot_flt, uv_flt, oc_flt} = 3'b111;
        pwr_req = 1'b1;
        pgood = 1'b0;
        step(1);
        chk("R2 ramp sw_en", int'(sw_en), 1);
        chk("R7 first ramp fast", int'(ramp_slow), 0);
        for (int k = 0; k <= RLIM; k++) begin
            int w;
            step(WIN - 1);
            chk("R4 still ramp", int'(state_o), 1);
            chk("R3 switch on in window", int'(sw_en), 1);
            step(1);
            chk("R3 timeout code", int'(ev_code), 4);
            chk("R12 timeout count", int'(ev_count), k + 1);
            {ot_flt, uv_flt, oc_flt} = 3'b000;
            if (k < RLIM) begin
                chk("R7 backoff state", int'(state_o), 3);
                w = BASE << k;
                if (w > BMAX) w = BMAX;
                step(w - 1);
                chk("R7 still waiting", int'(state_o), 3);
                chk("R7 switch off in wait", int'(sw_en), 0);
                step(1);
                chk("R7 retry ramp", int'(state_o), 1);
                chk("R7 retry code", int'(ev_code), 5);
                chk("R7 slow ramp", int'(ramp_slow), 1);
                chk("R7 retry count", int'(retry_cnt_o), k + 1);
            end else begin
                chk("R8 latched", int'(state_o), 4);
            end
        end

        // R9: latch holds with request high
        step(5);
        chk("R9 latched hold", int'(state_o), 4);
        chk("R9 switch off", int'(sw_en), 0);

        // R10: clear releases the latch
        svc_clr = 1'b1;
        step(1);
        svc_clr = 1'b0;
        chk("R10 to off", int'(state_o), 0);
        chk("R10 clear code", int'(ev_code), 6);
        chk("R10 count zero", int'(ev_count), 0);
        chk("R10 retry zero", int'(retry_cnt_o), 0);
        bring_up();
        svc_clr = 1'b1;
        step(1);
        svc_clr = 1'b0;
        chk("R10 ignored state", int'(state_o), 2);
        chk("R10 ignored event", int'(ev_valid), 0);

        // R6: one limit event per flag assertion
        cfg_rsp_ot = 2'b01;
        ot_flt = 1'b1;
        step(1);
        chk("R6 limit code", int'(ev_code), 11);
        chk("R6 limit count", int'(ev_count), 1);
        step(3);
        chk("R6 no repeat", int'(ev_valid), 0);
        chk("R6 stays on", int'(state_o), 2);
        ot_flt = 1'b0;
        step(1);
        ot_flt = 1'b1;
        step(1);
        chk("R6 reassert event", int'(ev_code), 11);
        chk("R12 count step", int'(ev_count), 2);
        ot_flt = 1'b0;

        // R2: dropping the request powers down
        pwr_req = 1'b0;
        step(1);
        chk("R2 drop to off", int'(state_o), 0);
        chk("R2 drop sw_en", int'(sw_en), 0);

        // R11: qualification restores the retry budget
        do_reset();
        bring_up();
        oc_flt = 1'b1;
        step(1);
        oc_flt = 1'b0;
        chk("R11 retry taken", int'(retry_cnt_o), 1);
        step(BASE);
        chk("R11 back in ramp", int'(state_o), 1);
        step(1);
        chk("R11 on again", int'(state_o), 2);
        step(QUAL - 1);
        chk("R11 not yet cleared", int'(retry_cnt_o), 1);
        step(1);
        chk("R11 cleared", int'(retry_cnt_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule